// File: doc/BRIEF.md
# Pulse-Coded Isolation Channel

This block models a channel that carries one logic level across an isolation barrier using short pulses instead of a steady level. The sending half watches a single-bit input. Each rising transition becomes a pulse on a set line, and each falling transition becomes a pulse on a clear line. While the input sits still, the sending half re-sends its current level at a fixed interval, so the far side stays correct even if an edge pulse was lost.

The receiving half is a bistable latch steered by those pulses. A no-pulse watchdog and a per-side supply-good flag decide whether the output is valid. When the pulses stop, or when either supply is reported bad, the output enable drops to the high-impedance default and the latched level is cleared to low.

The set and clear lines leave the top as outputs. The receive lines enter as separate inputs, so the surrounding logic (or a bench) forms the barrier between them. All timing is counted in clock cycles and set by parameters.

Top module: `iso_pulse_link`

## Requirements
- R1: The sender's output is one cycle behind its input. The cycle after a rising input transition is sampled, `set_pulse` is high for PULSE_W cycles. A falling transition does the same on `clr_pulse`.
- R2: If the input has not changed for REFRESH_CYC cycles, the sender emits a pulse that carries the current level: `set_pulse` if the input is 1, `clr_pulse` if it is 0. It repeats this every REFRESH_CYC cycles for as long as the input stays idle.
- R3: Every input transition and every refresh pulse restarts the refresh interval. A refresh therefore comes exactly REFRESH_CYC cycles after the most recent pulse the sender emitted.
- R4: `set_pulse` and `clr_pulse` are never high together. While `tx_supply_ok` is 0, both lines stay low from the next cycle on, and input transitions are not sent.
- R5: A received set alone (`rx_set`=1, `rx_clr`=0) makes `dout`=1 and `dout_en`=1 one cycle later. A received clear alone makes `dout`=0 and `dout_en`=1. With no pulse, both outputs hold.
- R6: If `rx_set` and `rx_clr` are both 1 in the same cycle, `dout` and `dout_en` keep their previous values. That cycle still counts as pulse activity for the watchdog.
- R7: The watchdog restarts on every cycle in which either receive line is high. Once TIMEOUT_CYC+1 cycles have passed with no pulse, `dout_en` drops to 0 and `dout` is cleared to 0.
- R8: After a timeout, the first valid pulse sets `dout_en` to 1 and loads the level that pulse carries, in the same cycle.
- R9: While `rx_supply_ok` is 0, `dout_en` and `dout` are 0 from the next cycle on. At power-up, the output stays disabled until that flag is 1 and a valid pulse has arrived.
- R10: During and after reset, before any pulse, `set_pulse`, `clr_pulse`, `dout` and `dout_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Level to be carried across the barrier |
| tx_supply_ok | input | 1 | Sending-side supply above its lockout threshold |
| rx_supply_ok | input | 1 | Receiving-side supply above its lockout threshold |
| set_pulse | output | 1 | Transmitted pulse meaning "level is high" |
| clr_pulse | output | 1 | Transmitted pulse meaning "level is low" |
| rx_set | input | 1 | Set pulse after crossing the barrier |
| rx_clr | input | 1 | Clear pulse after crossing the barrier |
| dout | output | 1 | Recovered level, 0 whenever disabled |
| dout_en | output | 1 | 1 = output driven, 0 = high-impedance default |

## Verification
The bench keeps a behavioural model of both halves and compares all four outputs on every clock. It also makes named spot checks after each scenario. It aims at the refresh timing after an idle stretch that is cut short by a mid-interval edge: a counter that does not restart on edges would send its refresh early. It also forces set and clear together, where a latch with a priority would flip instead of holding. It cuts the link and also powers down the sender, to confirm the enable drops exactly one cycle past the timeout and that stale data is cleared. A design that missed either would either keep driving a frozen level or present an old 1 when it re-enables. Finally, it raises the receive supply after the sender is already active, to confirm that supply-good alone does not re-enable the output without a pulse.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_SET  = 2'd1,
    PK_CLR  = 2'd2,
    PK_BOTH = 2'd3
  } pulse_kind_t;

  // Sorts the two receive lines into one pulse kind.
  function automatic pulse_kind_t classify(input logic s, input logic c);
    return pulse_kind_t'({c, s});
  endfunction

  // Width a counter needs to reach the value lim.
  function automatic int cnt_width(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/iso_edge_encoder.sv
module iso_edge_encoder
  import iso_link_pkg::*;
#(
  parameter int PULSE_W     = 1,
  parameter int REFRESH_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_ok,
  input  logic din,
  output logic set_o,
  output logic clr_o
);
  localparam int RW = cnt_width(REFRESH_CYC - 1);
  localparam int PW = cnt_width(PULSE_W);

  logic          din_q;
  logic [RW-1:0] idle_cnt;
  logic [PW-1:0] left;
  logic          lvl;

  // Named internal events
  logic rise_evt, fall_evt, edge_evt, refresh_evt, fire_evt;
  assign rise_evt    = tx_ok && din && !din_q;
  assign fall_evt    = tx_ok && !din && din_q;
  assign edge_evt    = rise_evt || fall_evt;
  assign refresh_evt = tx_ok && !edge_evt && (idle_cnt == RW'(REFRESH_CYC - 1));
  assign fire_evt    = edge_evt || refresh_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q    <= 1'b0;
      idle_cnt <= '0;
      left     <= '0;
      lvl      <= 1'b0;
    end else begin
      din_q <= din;
      if (!tx_ok) begin
        idle_cnt <= '0;
        left     <= '0;
      end else begin
        if (fire_evt) idle_cnt <= '0;
        else          idle_cnt <= idle_cnt + 1'b1;
        if (fire_evt) begin
          left <= PW'(PULSE_W);
          lvl  <= din;
        end else if (left != '0) begin
          left <= left - 1'b1;
        end
      end
    end
  end

  assign set_o = (left != '0) && lvl;
  assign clr_o = (left != '0) && !lvl;

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_o && clr_o));
  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ok |=> !(set_o || clr_o));
  assert_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> set_o);
  assert_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> clr_o);

endmodule

// File: rtl/iso_pulse_watchdog.sv
module iso_pulse_watchdog
  import iso_link_pkg::*;
#(
  parameter int TIMEOUT_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_ok,
  input  logic activity,
  output logic expired
);
  localparam int WW = cnt_width(TIMEOUT_CYC);

  logic [WW-1:0] cnt;

  assign expired = (cnt == WW'(TIMEOUT_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_ok || activity) cnt <= '0;
    else if (!expired)                cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/iso_latch_decoder.sv
module iso_latch_decoder
  import iso_link_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_ok,
  input  pulse_kind_t kind,
  input  logic        expired,
  output logic        q,
  output logic        en
);

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_ok) begin
      q  <= 1'b0;
      en <= 1'b0;
    end else begin
      unique case (kind)
        PK_SET:  begin q <= 1'b1; en <= 1'b1; end
        PK_CLR:  begin q <= 1'b0; en <= 1'b1; end
        PK_BOTH: ;
        default: if (expired) begin q <= 1'b0; en <= 1'b0; end
      endcase
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ok && kind == PK_BOTH) |=> ($stable(q) && $stable(en)));
  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ok && kind == PK_SET) |=> (q && en));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !q);
  assert_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ok |=> (!en && !q));

endmodule

// File: rtl/iso_pulse_link.sv
module iso_pulse_link
  import iso_link_pkg::*;
#(
  parameter int PULSE_W     = 1,
  parameter int REFRESH_CYC = 100,
  parameter int TIMEOUT_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic tx_supply_ok,
  input  logic rx_supply_ok,
  output logic set_pulse,
  output logic clr_pulse,
  input  logic rx_set,
  input  logic rx_clr,
  output logic dout,
  output logic dout_en
);

  pulse_kind_t rx_kind;
  logic        rx_activity;
  logic        wd_expired;

  assign rx_kind     = classify(rx_set, rx_clr);
  assign rx_activity = (rx_kind != PK_NONE);

  iso_edge_encoder #(.PULSE_W(PULSE_W), .REFRESH_CYC(REFRESH_CYC)) u_enc (
    .clk(clk), .rst_n(rst_n), .tx_ok(tx_supply_ok), .din(din),
    .set_o(set_pulse), .clr_o(clr_pulse)
  );

  iso_pulse_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
    .clk(clk), .rst_n(rst_n), .rx_ok(rx_supply_ok),
    .activity(rx_activity), .expired(wd_expired)
  );

  iso_latch_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .rx_ok(rx_supply_ok), .kind(rx_kind),
    .expired(wd_expired), .q(dout), .en(dout_en)
  );

endmodule

// File: tb/iso_pulse_link_bench.sv
module iso_pulse_link_bench;
  localparam int PW = 1;
  localparam int RF = 100;
  localparam int TO = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0;
  logic set_pulse, clr_pulse, dout, dout_en;
  logic rx_set, rx_clr;
  int   mode = 0;               // 0 loopback, 1 inject, 2 cut
  logic inj_s = 1'b0, inj_c = 1'b0;

  int total = 0, bad = 0;
  string tag = "R10";
  bit done = 0;

  always #4 clk = ~clk;

  assign rx_set = (mode == 0) ? set_pulse : (mode == 1) ? inj_s : 1'b0;
  assign rx_clr = (mode == 0) ? clr_pulse : (mode == 1) ? inj_c : 1'b0;

  iso_pulse_link #(.PULSE_W(PW), .REFRESH_CYC(RF), .TIMEOUT_CYC(TO)) u_iso_pulse_link (
    .clk(clk), .rst_n(rst_n), .din(din), .tx_supply_ok(tx_ok),
    .rx_supply_ok(rx_ok), .set_pulse(set_pulse), .clr_pulse(clr_pulse),
    .rx_set(rx_set), .rx_clr(rx_clr), .dout(dout), .dout_en(dout_en)
  );

  // Behavioural reference model
  int m_since = 0;      // cycles since last sent pulse
  int m_plen = 0;       // remaining pulse cycles
  bit m_plvl = 0, m_prev = 0;
  int m_quiet = 0;      // cycles since last received pulse
  bit m_q = 0, m_en = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_since = 0; m_plen = 0; m_plvl = 0; m_prev = 0;
      m_quiet = 0; m_q = 0; m_en = 0;
    end else begin
      bit s, c;
      s = rx_set; c = rx_clr;
      if (!rx_ok) begin
        m_q = 0; m_en = 0; m_quiet = 0;
      end else begin
        if (s && !c)       begin m_q = 1; m_en = 1; end
        else if (c && !s)  begin m_q = 0; m_en = 1; end
        else if (!s && !c && m_quiet >= TO) begin m_q = 0; m_en = 0; end
        if (s || c) m_quiet = 0;
        else if (m_quiet < TO) m_quiet++;
      end
      if (!tx_ok) begin
        m_since = 0; m_plen = 0;
      end else if (din != m_prev || m_since == RF - 1) begin
        m_since = 0; m_plen = PW; m_plvl = din;
      end else begin
        m_since++;
        if (m_plen > 0) m_plen--;
      end
      m_prev = din;
    end
  end

  task automatic check(string t, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%b exp=%b at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag, "set_pulse", set_pulse, (m_plen > 0) && m_plvl);
      check(tag, "clr_pulse", clr_pulse, (m_plen > 0) && !m_plvl);
      check(tag, "dout", dout, m_q);
      check(tag, "dout_en", dout_en, m_en);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(4);
    check("R10", "rst set", set_pulse, 1'b0);
    check("R10", "rst clr", clr_pulse, 1'b0);
    check("R10", "rst dout", dout, 1'b0);
    check("R10", "rst en", dout_en, 1'b0);
    rst_n = 1'b1;
    // power-up ordering: sender first
    tag = "R9"; tx_ok = 1'b1; step(3);
    din = 1'b1; step(5);
    check("R9", "en before rx supply", dout_en, 1'b0);
    din = 1'b0; step(3);
    rx_ok = 1'b1; step(3);
    check("R9", "en without pulse", dout_en, 1'b0);
    // single edges
    tag = "R1"; din = 1'b1; step(1);
    check("R1", "set after rise", set_pulse, 1'b1);
    step(1);
    check("R1", "set width", set_pulse, 1'b0);
    check("R5", "dout after set", dout, 1'b1);
    check("R8", "enable by first pulse", dout_en, 1'b1);
    din = 1'b0; step(1);
    check("R1", "clr after fall", clr_pulse, 1'b1);
    step(2);
    check("R5", "dout after clr", dout, 1'b0);
    // idle with refresh, then edge mid-interval
    tag = "R2"; din = 1'b1; step(250);
    check("R2", "en kept by refresh", dout_en, 1'b1);
    tag = "R3"; step(40); din = 1'b0; step(150);
    check("R3", "dout after restart", dout, 1'b0);
    // simultaneous set and clear
    tag = "R6"; mode = 1; inj_s = 1'b1; inj_c = 1'b1; step(1);
    inj_s = 1'b0; inj_c = 1'b0; step(2);
    check("R6", "both held dout", dout, 1'b0);
    check("R6", "both held en", dout_en, 1'b1);
    tag = "R5"; inj_s = 1'b1; step(1); inj_s = 1'b0; step(1);
    check("R5", "injected set", dout, 1'b1);
    // link cut
    tag = "R7"; mode = 2; step(TO + 5);
    check("R7", "en after timeout", dout_en, 1'b0);
    check("R7", "dout cleared", dout, 1'b0);
    tag = "R8"; mode = 0; din = 1'b1; step(3);
    check("R8", "reenable", dout_en, 1'b1);
    check("R8", "loaded level", dout, 1'b1);
    // sender power loss
    tag = "R4"; tx_ok = 1'b0; din = 1'b0; step(2); din = 1'b1; step(1);
    check("R4", "no pulse unpowered", set_pulse, 1'b0);
    step(TO + 5);
    check("R4", "timeout on tx loss", dout_en, 1'b0);
    tag = "R8"; tx_ok = 1'b1; step(RF + 5);
    check("R8", "en after refresh", dout_en, 1'b1);
    check("R8", "level after refresh", dout, 1'b1);
    // receive supply drop
    tag = "R9"; rx_ok = 1'b0; step(1);
    check("R9", "lockout en", dout_en, 1'b0);
    check("R9", "lockout dout", dout, 1'b0);
    step(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule